// File: doc/BRIEF.md
# Presettable Synchronous Down Counter

This block is an eight-bit down counter for dividers, programmable timers and event countdowns. On every rising clock edge it steps down by one while its active-low count enable is asserted. A build parameter selects how the eight bits are read: either as one plain binary value, or as two decimal digits of four bits each. In the decimal case the ones digit sits in bits 3:0 and the tens digit in bits 7:4.

A jam value can be put into the counter in two ways. The first is a synchronous load taken on the next clock edge. The second is an asynchronous load that acts at once, with no clock. An active-low clear drives the counter to its top value, which is 255 in binary and 8'h99 in decimal.

The active-low zero flag falls while the count is zero and counting is enabled. This flag is meant to feed the count enable of a following stage, so that several counters form one wider down counter. The present count is also driven out for observation.

Top module: `preset_down_counter`

## Requirements
- R1: With clear, both loads inactive and `count_en_n` low, each rising clock edge lowers the count by exactly one in the selected encoding.
- R2: With clear and both loads inactive and `count_en_n` high, the count holds across clock edges.
- R3: While `sync_load_n` is low (clear and asynchronous load inactive), the next rising edge copies `load_value` into the count whatever `count_en_n` is; the count does not change before that edge.
- R4: Pulling `async_load_n` low copies `load_value` into the count at once, without a clock edge, overriding `sync_load_n` and `count_en_n`; the count stays there while it is held low across edges.
- R5: Pulling `clear_n` low forces the count at once to the top value (8'hFF in binary, 8'h99 in decimal), overriding every other input including `async_load_n`.
- R6: `zero_n` is low exactly while the count equals 8'h00 and `count_en_n` is low, and follows `count_en_n` without waiting for a clock edge.
- R7: Decrementing from zero wraps to the top value, so a free-running count repeats every 256 edges in binary and every 100 edges in decimal.
- R8: In decimal mode each four-bit digit runs 9 down to 0; when the ones digit (bits 3:0) steps below 0 it becomes 9 and the tens digit (bits 7:4) drops by one.
- R9: When a second stage takes its `count_en_n` from the first stage's `zero_n`, and both share clock and controls, the pair behaves as one down counter of twice the width (modulo 65536 in binary, 10000 in decimal).
- R10: Parameter `BCD_MODE` = 0 selects the binary encoding and `BCD_MODE` = 1 selects the two-digit decimal encoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| clear_n | input | 1 | Asynchronous clear to the top value, active low, highest priority |
| async_load_n | input | 1 | Asynchronous load of `load_value`, active low |
| sync_load_n | input | 1 | Load of `load_value` on the next rising edge, active low |
| count_en_n | input | 1 | Count enable and cascade carry-in, active low |
| load_value | input | 8 | Jam value, in the selected encoding |
| zero_n | output | 1 | Zero flag and cascade carry-out, active low |
| count | output | 8 | Present count, in the selected encoding |

## Verification
The bench runs binary and decimal two-stage chains against a wide-integer model at every step. This shows up a lower digit that does not borrow correctly, for example going from 8'h10 to 8'h0F instead of 8'h09, or wrapping from zero to zero rather than to the top value. Priority is probed by asserting clear together with the asynchronous load. The asynchronous load is applied between edges, and the synchronous load is applied with counting enabled. A design with the wrong order would keep the jam value or decrement on that edge. The zero flag is toggled through the enable alone while the count sits at zero. A registered flag would lag one cycle and make the upper stage of the chain miss or double its borrow.

// File: rtl/pdc_pkg.sv
// Shared constants and helpers for the presettable down counter.
// Assumes the count width is a whole number of four-bit decimal digits.
package pdc_pkg;

    localparam int COUNT_W     = 8;
    localparam int BCD_DIGIT_W = 4;
    localparam int BCD_RADIX   = 10;

    // Number of digit slices used by the selected encoding.
    function automatic int digit_count(bit bcd);
        return bcd ? (COUNT_W / BCD_DIGIT_W) : 1;
    endfunction

    // Radix of one digit slice for the selected encoding.
    function automatic int digit_radix(bit bcd);
        return bcd ? BCD_RADIX : (1 << COUNT_W);
    endfunction

    // Top value loaded by clear and reached on wrap from zero.
    function automatic logic [COUNT_W-1:0] max_code(bit bcd);
        logic [COUNT_W-1:0] code;
        code = '1;
        if (bcd) begin
            for (int i = 0; i < COUNT_W / BCD_DIGIT_W; i++) begin
                code[i*BCD_DIGIT_W +: BCD_DIGIT_W] = BCD_DIGIT_W'(BCD_RADIX - 1);
            end
        end
        return code;
    endfunction

endpackage

// File: rtl/pdc_digit_dec.sv
// One digit slice of the decrementer.
// Steps the digit down by one when borrow_in is set, wrapping from 0 to
// RADIX-1 and raising borrow_out on that wrap. Assumes digit_in < RADIX.
module pdc_digit_dec #(
    parameter int W     = 4,
    parameter int RADIX = 10
) (
    input  logic [W-1:0] digit_in,
    input  logic         borrow_in,
    output logic [W-1:0] digit_out,
    output logic         borrow_out
);

    localparam logic [W-1:0] TOP = W'(RADIX - 1);

    logic at_floor;

    // Next digit value and outgoing borrow.
    always_comb begin
        at_floor   = (digit_in == '0);
        borrow_out = borrow_in && at_floor;
        if (!borrow_in) begin
            digit_out = digit_in;
        end else if (at_floor) begin
            digit_out = TOP;
        end else begin
            digit_out = digit_in - W'(1);
        end
    end

endmodule

// File: rtl/pdc_next_count.sv
// Next-count logic: a chain of digit slices, one slice for binary,
// two four-bit decimal slices otherwise. wrap is set when the whole value
// would pass below zero. Assumes each decimal digit holds 0..9.
module pdc_next_count
    import pdc_pkg::*;
#(
    parameter bit BCD_MODE = 1'b0
) (
    input  logic [COUNT_W-1:0] cur,
    output logic [COUNT_W-1:0] nxt,
    output logic               wrap
);

    localparam int ND  = digit_count(BCD_MODE);
    localparam int DW  = COUNT_W / ND;
    localparam int RAD = digit_radix(BCD_MODE);

    logic [ND:0] borrow;

    // The lowest slice always receives the decrement request.
    assign borrow[0] = 1'b1;

    for (genvar g = 0; g < ND; g++) begin : g_digit
        pdc_digit_dec #(
            .W     (DW),
            .RADIX (RAD)
        ) u_digit (
            .digit_in   (cur[g*DW +: DW]),
            .borrow_in  (borrow[g]),
            .digit_out  (nxt[g*DW +: DW]),
            .borrow_out (borrow[g+1])
        );
    end

    // Borrow leaving the top slice marks a full wrap.
    assign wrap = borrow[ND];

endmodule

// File: rtl/pdc_zero_detect.sv
// Active-low zero flag, also the carry-out for chaining stages.
// Purely combinational so a following stage sees it in the same cycle.
module pdc_zero_detect
    import pdc_pkg::*;
(
    input  logic [COUNT_W-1:0] cur,
    input  logic               en_n,
    output logic               zero_n
);

    // Low only when the value is zero and counting is enabled.
    always_comb begin
        zero_n = !((cur == '0) && !en_n);
    end

endmodule

// File: rtl/preset_down_counter.sv
// Presettable eight-bit down counter, binary or two-digit decimal.
// Priority: clear, asynchronous load, synchronous load, count.
// Assumes load_value is stable while async_load_n is low and holds a valid
// code for the selected encoding.
module preset_down_counter
    import pdc_pkg::*;
#(
    parameter bit BCD_MODE = 1'b0
) (
    input  logic               clk,
    input  logic               clear_n,
    input  logic               async_load_n,
    input  logic               sync_load_n,
    input  logic               count_en_n,
    input  logic [COUNT_W-1:0] load_value,
    output logic               zero_n,
    output logic [COUNT_W-1:0] count
);

    localparam logic [COUNT_W-1:0] TOP_CODE = max_code(BCD_MODE);
    localparam int SPAN = BCD_MODE ? (10 ** (COUNT_W / 4)) : (2 ** COUNT_W);

    logic [COUNT_W-1:0] cnt_q;
    logic [COUNT_W-1:0] cnt_dec;
    logic               dec_wrap;

    pdc_next_count #(
        .BCD_MODE (BCD_MODE)
    ) u_next (
        .cur  (cnt_q),
        .nxt  (cnt_dec),
        .wrap (dec_wrap)
    );

    pdc_zero_detect u_zero (
        .cur    (cnt_q),
        .en_n   (count_en_n),
        .zero_n (zero_n)
    );

    // Count register with asynchronous clear and asynchronous load.
    always_ff @(posedge clk or negedge clear_n or negedge async_load_n) begin
        if (!clear_n) begin
            cnt_q <= TOP_CODE;
        end else if (!async_load_n) begin
            cnt_q <= load_value;
        end else if (!sync_load_n) begin
            cnt_q <= load_value;
        end else if (!count_en_n) begin
            cnt_q <= cnt_dec;
        end
    end

    assign count = cnt_q;

    // Reads a code as an integer in the selected encoding (checks only).
    function automatic int as_number(logic [COUNT_W-1:0] v);
        int acc = 0;
        for (int i = COUNT_W / 4 - 1; i >= 0; i--) begin
            acc = acc * (BCD_MODE ? 10 : 16) + int'(v[i*4 +: 4]);
        end
        return acc;
    endfunction

    // R1, R8: one enabled edge lowers the value by one modulo SPAN.
    a_r1_decrement: assert property (@(posedge clk)
        disable iff (!clear_n || !async_load_n)
        $past(clear_n && async_load_n && sync_load_n && !count_en_n)
        |-> (as_number(count) == (as_number($past(count)) + SPAN - 1) % SPAN));

    // R2: a disabled edge leaves the count alone.
    a_r2_hold: assert property (@(posedge clk)
        disable iff (!clear_n || !async_load_n)
        $past(clear_n && async_load_n && sync_load_n && count_en_n)
        |-> (count == $past(count)));

    // R3: a synchronous load takes the jam value regardless of enable.
    a_r3_sync_load: assert property (@(posedge clk)
        disable iff (!clear_n || !async_load_n)
        $past(clear_n && async_load_n && !sync_load_n)
        |-> (count == $past(load_value)));

    // R6: counting down from one with enable held raises the zero flag.
    a_r6_zero_after_one: assert property (@(posedge clk)
        disable iff (!clear_n || !async_load_n)
        ($past(clear_n && async_load_n && sync_load_n && !count_en_n
               && (count == COUNT_W'(1))) && !count_en_n)
        |-> !zero_n);

    // R7: a wrap from the next-count chain lands on the top value.
    a_r7_wrap_to_top: assert property (@(posedge clk)
        disable iff (!clear_n || !async_load_n)
        $past(clear_n && async_load_n && sync_load_n && !count_en_n && dec_wrap)
        |-> (count == TOP_CODE));

    // R7: the chain reports a wrap only from a zero count.
    a_r7_wrap_only_at_zero: assert property (@(posedge clk)
        disable iff (!clear_n)
        dec_wrap |-> (count == '0));

endmodule

// File: tb/preset_down_counter_bench.sv
// Directed bench: binary and decimal two-stage chains against an integer model.
module preset_down_counter_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       clr_n, apl_n, spl_n, en_n;
    logic [7:0] jam_bl, jam_bh, jam_dl, jam_dh;
    logic [7:0] cnt_bl, cnt_bh, cnt_dl, cnt_dh;
    logic       zn_bl, zn_bh, zn_dl, zn_dh;

    int total = 0;
    int bad   = 0;
    int m_bin = 0;
    int m_bcd = 0;

    preset_down_counter #(.BCD_MODE(1'b0)) u_preset_down_counter (
        .clk(clk), .clear_n(clr_n), .async_load_n(apl_n), .sync_load_n(spl_n),
        .count_en_n(en_n), .load_value(jam_bl), .zero_n(zn_bl), .count(cnt_bl));
    preset_down_counter #(.BCD_MODE(1'b0)) u_bin_hi (
        .clk(clk), .clear_n(clr_n), .async_load_n(apl_n), .sync_load_n(spl_n),
        .count_en_n(zn_bl), .load_value(jam_bh), .zero_n(zn_bh), .count(cnt_bh));
    preset_down_counter #(.BCD_MODE(1'b1)) u_bcd_lo (
        .clk(clk), .clear_n(clr_n), .async_load_n(apl_n), .sync_load_n(spl_n),
        .count_en_n(en_n), .load_value(jam_dl), .zero_n(zn_dl), .count(cnt_dl));
    preset_down_counter #(.BCD_MODE(1'b1)) u_bcd_hi (
        .clk(clk), .clear_n(clr_n), .async_load_n(apl_n), .sync_load_n(spl_n),
        .count_en_n(zn_dl), .load_value(jam_dh), .zero_n(zn_dh), .count(cnt_dh));

    function automatic logic [7:0] to_bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string req);
        int  lb = m_bin % 256;
        int  hb = m_bin / 256;
        int  ld = m_bcd % 100;
        int  hd = m_bcd / 100;
        bit  zlb = (lb == 0) && !en_n;
        bit  zhb = (hb == 0) && zlb;
        bit  zld = (ld == 0) && !en_n;
        bit  zhd = (hd == 0) && zld;
        check(req, "bin lo count", int'(cnt_bl), lb);
        check(req, "bin hi count", int'(cnt_bh), hb);
        check(req, "bcd lo count", int'(cnt_dl), int'(to_bcd(ld)));
        check(req, "bcd hi count", int'(cnt_dh), int'(to_bcd(hd)));
        check(req, "bin lo zero_n", int'(zn_bl), int'(!zlb));
        check(req, "bin hi zero_n", int'(zn_bh), int'(!zhb));
        check(req, "bcd lo zero_n", int'(zn_dl), int'(!zld));
        check(req, "bcd hi zero_n", int'(zn_dh), int'(!zhd));
    endtask

    task automatic load_model();
        m_bin = int'(jam_bh) * 256 + int'(jam_bl);
        m_bcd = from_bcd(jam_dh) * 100 + from_bcd(jam_dl);
    endtask

    // One clock edge: update the model from the controls, sample 1 ns later.
    task automatic step();
        @(posedge clk);
        if (clr_n && apl_n) begin
            if (!spl_n) load_model();
            else if (!en_n) begin
                m_bin = (m_bin + 65535) % 65536;
                m_bcd = (m_bcd + 9999) % 10000;
            end
        end
        #1;
    endtask

    task automatic set_jam(logic [7:0] bh, logic [7:0] bl, logic [7:0] dh, logic [7:0] dl);
        jam_bh = bh; jam_bl = bl; jam_dh = dh; jam_dl = dl;
    endtask

    task automatic t_reset();
        clr_n = 1'b0; apl_n = 1'b1; spl_n = 1'b0; en_n = 1'b0;
        set_jam(8'h12, 8'h34, 8'h12, 8'h34);
        m_bin = 65535; m_bcd = 9999;
        repeat (3) step();
        check_all("R5 R10 clear to top");
        clr_n = 1'b1; spl_n = 1'b1;
    endtask

    task automatic t_decrement();
        for (int i = 0; i < 20; i++) begin
            step();
            check_all("R1 decrement");
        end
    endtask

    task automatic t_hold();
        en_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            step();
            check_all("R2 hold");
        end
    endtask

    task automatic t_sync_load();
        set_jam(8'h03, 8'h5A, 8'h12, 8'h47);
        spl_n = 1'b0; en_n = 1'b1;
        #1;
        check_all("R3 no change before edge");
        step();
        check_all("R3 load with enable off");
        set_jam(8'h00, 8'hC3, 8'h00, 8'h58);
        en_n = 1'b0;
        step();
        check_all("R3 load with enable on");
        spl_n = 1'b1;
    endtask

    task automatic t_async_load();
        set_jam(8'h7E, 8'h21, 8'h63, 8'h81);
        spl_n = 1'b0; en_n = 1'b0;
        apl_n = 1'b0;
        #1;
        load_model();
        check_all("R4 immediate load");
        step();
        check_all("R4 held across edge");
        apl_n = 1'b1; spl_n = 1'b1;
        step();
        check_all("R4 counts after release");
    endtask

    task automatic t_clear_priority();
        set_jam(8'h11, 8'h22, 8'h11, 8'h22);
        clr_n = 1'b0; apl_n = 1'b0;
        #1;
        m_bin = 65535; m_bcd = 9999;
        check_all("R5 clear beats async load");
        step();
        check_all("R5 clear held");
        clr_n = 1'b1; apl_n = 1'b1;
        step();
        check_all("R5 R1 count from top");
    endtask

    task automatic t_zero_flag();
        set_jam(8'h00, 8'h02, 8'h00, 8'h02);
        spl_n = 1'b0; en_n = 1'b1;
        step();
        spl_n = 1'b1; en_n = 1'b0;
        #1;
        check_all("R6 count two");
        step();
        check_all("R6 count one");
        step();
        check_all("R6 flag at zero");
        en_n = 1'b1;
        #1;
        check_all("R6 flag drops with enable");
        en_n = 1'b0;
        #1;
        check_all("R6 flag returns with enable");
        step();
        check_all("R7 R9 wrap of both stages");
    endtask

    task automatic t_full_cycle();
        set_jam(8'h01, 8'h00, 8'h01, 8'h00);
        spl_n = 1'b0;
        step();
        spl_n = 1'b1;
        for (int i = 1; i <= 256; i++) begin
            step();
            check_all("R7 R9 free run");
            if (i == 100) check("R7", "bcd lo back to zero", int'(cnt_dl), 0);
            if (i == 256) check("R7", "bin lo back to zero", int'(cnt_bl), 0);
        end
    endtask

    task automatic t_bcd_borrow();
        set_jam(8'h00, 8'h10, 8'h00, 8'h10);
        spl_n = 1'b0;
        step();
        spl_n = 1'b1;
        step();
        check_all("R8 ones borrow");
        check("R8", "bcd lo after 10", int'(cnt_dl), 8'h09);
    endtask

    task automatic t_cascade();
        set_jam(8'h03, 8'h01, 8'h03, 8'h01);
        spl_n = 1'b0;
        step();
        spl_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            check_all("R9 cascade borrow");
        end
        check("R9", "bin hi after borrow", int'(cnt_bh), 2);
        check("R9", "bcd hi after borrow", int'(cnt_dh), 8'h02);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_decrement();
        t_hold();
        t_sync_load();
        t_async_load();
        t_clear_priority();
        t_zero_flag();
        t_full_cycle();
        t_bcd_borrow();
        t_cascade();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule